// File: doc/BRIEF.md
# Shared Dual-Channel Integral Compensator

This block is the digital loop filter of a two-output switching regulator. For each of two output channels it holds a 12-bit duty-cycle accumulator. On every sample tick it runs an integral update: it takes a feedback code, subtracts the channel's reference, multiplies the difference by the channel's gain, and subtracts that product from the stored duty word. The upper 10 bits of each accumulator are presented to an external PWM generator.

One subtract-multiply-accumulate datapath is shared by both channels. After a tick, channel 0 is processed in the first cycle and channel 1 in the next. The feedback code of each channel is taken from one of two 7-bit inputs. One input is the converter's ADC result and the other is a delay-count word from a speed monitor. A per-channel select picks between them. The references, the gains, the source selects and the sample-period count are plain register inputs, held steady by surrounding configuration logic.

The sample tick is produced inside the block by a free-running counter. Its period is set by `period_i`.

Top module: `dual_integral_comp`

## Requirements
- R1: While `rst_ni` is low and after its release, both accumulators are 0. `duty_o` reads 0 and `upd_o` reads 0 until the first update.
- R2: For channel c the update is next = prev - (meas_c - ref_c) * gain_c. The terms are signed and taken at full width, with no scaling. `gain_i` is unsigned. Each channel uses only its own slices: channel c occupies bits [c*7 +: 7] of the code inputs and [c*8 +: 8] of `gain_i`.
- R3: The accumulator saturates. A result below 0 becomes 0 and a result above 4095 becomes 4095; it never wraps.
- R4: `duty_o` bits [c*10 +: 10] carry accumulator bits [11:2] of channel c. Accumulator values 3 and 4 read as 0 and 1.
- R5: When `src_dly_i[c]` is 1, channel c uses `meas_dly_i`; when it is 0, it uses `meas_adc_i`. The unselected code has no effect on the result.
- R6: The sample tick recurs every `period_i`+1 clock cycles.
- R7: After a tick, channel 0 is updated first and channel 1 one cycle later. Each update raises `upd_o[c]` for exactly one cycle, in the same cycle the new command appears on `duty_o`. The two pulses are never high together.
- R8: With a gain of 0, or with meas equal to ref, an update leaves the command unchanged.
- R9: A channel's `duty_o` changes only in a cycle where its `upd_o` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| meas_adc_i | input | 14 | ADC feedback codes, 7 bits per channel |
| meas_dly_i | input | 14 | Delay-count feedback codes, 7 bits per channel |
| ref_i | input | 14 | Per-channel reference, 7 bits each |
| gain_i | input | 16 | Per-channel unsigned gain, 8 bits each |
| src_dly_i | input | 2 | Per-channel source select, 1 selects delay count |
| period_i | input | 16 | Sample period minus one, in clock cycles |
| duty_o | output | 20 | Per-channel PWM command, 10 bits each |
| upd_o | output | 2 | Per-channel one-cycle update pulse |

## Verification
The embedded assertions check several properties on every cycle: the update pulses never overlap, and channel 1 always follows channel 0. A duty word never moves without its pulse. A positive error never raises a command. No two ticks fall back-to-back when the period is non-zero. The arithmetic cannot be checked that way and needs the bench's scenarios. Those scenarios cover the exact integral result, clamping at both rails, truncation of the two low bits, and the fact that the unselected feedback source has no effect. They also cover tick spacing under two different periods.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int unsigned NCH_DEF    = 2;
  localparam int unsigned MEAS_W_DEF = 7;
  localparam int unsigned GAIN_W_DEF = 8;
  localparam int unsigned DUTY_W_DEF = 12;
  localparam int unsigned PWM_W_DEF  = 10;
  localparam int unsigned DIV_W_DEF  = 16;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dic_sample_timer.sv
module dic_sample_timer #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] period_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R6: a non-zero period never yields adjacent ticks
  p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && period_i != '0 && $stable(period_i)) |=> !tick_o);
endmodule

// File: rtl/dic_channel_seq.sv
module dic_channel_seq
  import dic_pkg::*;
#(
  parameter int unsigned NCH = 2,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic            busy_o,
  output logic [CH_W-1:0] ch_o
);
  seq_state_e      state_q;
  logic [CH_W-1:0] ch_q;
  logic            last_ch;

  assign last_ch = (ch_q == CH_W'(NCH - 1));
  assign busy_o  = (state_q == SEQ_RUN);
  assign ch_o    = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ch_q    <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (tick_i) begin
          state_q <= SEQ_RUN;
          ch_q    <= '0;
        end
        SEQ_RUN: begin
          if (last_ch) begin
            state_q <= SEQ_IDLE;
            ch_q    <= '0;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R7: each sequence starts at channel 0
  p_start_ch0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (ch_o == '0));
  // R7: channels advance in ascending order
  p_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_ch) |=> (busy_o && ch_o == $past(ch_o) + 1'b1));
endmodule

// File: rtl/dic_update_path.sv
module dic_update_path #(
  parameter int unsigned MEAS_W = 7,
  parameter int unsigned GAIN_W = 8,
  parameter int unsigned DUTY_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [MEAS_W-1:0] meas_i,
  input  logic [MEAS_W-1:0] ref_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [DUTY_W-1:0] cur_i,
  output logic [DUTY_W-1:0] nxt_o
);
  localparam int unsigned ERR_W  = MEAS_W + 1;
  localparam int unsigned PROD_W = ERR_W + GAIN_W + 1;
  localparam int unsigned BASE_W = (PROD_W > DUTY_W) ? PROD_W : DUTY_W;
  localparam int unsigned SUM_W  = BASE_W + 2;
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'({DUTY_W{1'b1}});

  logic signed [ERR_W-1:0]  err;
  logic signed [PROD_W-1:0] err_x, gain_x, prod;
  logic signed [SUM_W-1:0]  cur_x, sum;

  always_comb begin
    err    = $signed({1'b0, meas_i}) - $signed({1'b0, ref_i});
    err_x  = PROD_W'(err);
    gain_x = $signed(PROD_W'({1'b0, gain_i}));
    prod   = err_x * gain_x;
    cur_x  = $signed(SUM_W'({1'b0, cur_i}));
    sum    = cur_x - SUM_W'(prod);
    if (sum < 0)          nxt_o = '0;
    else if (sum > MAX_S) nxt_o = {DUTY_W{1'b1}};
    else                  nxt_o = sum[DUTY_W-1:0];
  end

  // R2/R3: a positive error can only lower or hold the command
  p_dir_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && meas_i > ref_i) |-> (nxt_o <= cur_i));
  // R2/R3: a negative error can only raise or hold the command
  p_dir_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && meas_i < ref_i) |-> (nxt_o >= cur_i));
  // R8: zero gain or zero error holds the command
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (gain_i == '0 || meas_i == ref_i)) |-> (nxt_o == cur_i));
endmodule

// File: rtl/dual_integral_comp.sv
module dual_integral_comp
  import dic_pkg::*;
#(
  parameter int unsigned NCH    = NCH_DEF,
  parameter int unsigned MEAS_W = MEAS_W_DEF,
  parameter int unsigned GAIN_W = GAIN_W_DEF,
  parameter int unsigned DUTY_W = DUTY_W_DEF,
  parameter int unsigned PWM_W  = PWM_W_DEF,
  parameter int unsigned DIV_W  = DIV_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NCH*MEAS_W-1:0]   meas_adc_i,
  input  logic [NCH*MEAS_W-1:0]   meas_dly_i,
  input  logic [NCH*MEAS_W-1:0]   ref_i,
  input  logic [NCH*GAIN_W-1:0]   gain_i,
  input  logic [NCH-1:0]          src_dly_i,
  input  logic [DIV_W-1:0]        period_i,
  output logic [NCH*PWM_W-1:0]    duty_o,
  output logic [NCH-1:0]          upd_o
);
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic            tick, busy;
  logic [CH_W-1:0] ch;
  logic [MEAS_W-1:0] meas_sel, ref_sel;
  logic [GAIN_W-1:0] gain_sel;
  logic [DUTY_W-1:0] cur_sel, nxt;
  logic [DUTY_W-1:0] duty_q [NCH];
  logic [NCH-1:0]    upd_q;

  dic_sample_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i, .rst_ni, .period_i, .tick_o(tick)
  );

  dic_channel_seq #(.NCH(NCH)) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .busy_o(busy), .ch_o(ch)
  );

  always_comb begin
    meas_sel = src_dly_i[ch] ? meas_dly_i[ch*MEAS_W +: MEAS_W]
                             : meas_adc_i[ch*MEAS_W +: MEAS_W];
    ref_sel  = ref_i[ch*MEAS_W +: MEAS_W];
    gain_sel = gain_i[ch*GAIN_W +: GAIN_W];
    cur_sel  = duty_q[ch];
  end

  dic_update_path #(.MEAS_W(MEAS_W), .GAIN_W(GAIN_W), .DUTY_W(DUTY_W)) u_path (
    .clk_i, .rst_ni, .valid_i(busy), .meas_i(meas_sel), .ref_i(ref_sel),
    .gain_i(gain_sel), .cur_i(cur_sel), .nxt_o(nxt)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    logic we;
    assign we = busy && (ch == CH_W'(gi));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        duty_q[gi] <= '0;
        upd_q[gi]  <= 1'b0;
      end else begin
        upd_q[gi] <= we;
        if (we) duty_q[gi] <= nxt;
      end
    end

    assign duty_o[gi*PWM_W +: PWM_W] = duty_q[gi][DUTY_W-1 -: PWM_W];

    // R9: command moves only with its update pulse
    p_move_with_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (duty_q[gi] != $past(duty_q[gi])) |-> upd_q[gi]);

    if (gi > 0) begin : g_follow
      // R7: channel gi updates right after channel gi-1
      p_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_q[gi] |-> $past(upd_q[gi-1]));
    end
  end

  assign upd_o = upd_q;

  // R7: update pulses never overlap
  p_pulse_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_q));
endmodule

// File: tb/dual_integral_comp_test.sv
module dual_integral_comp_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] meas_adc, meas_dly, ref_v;
  logic [15:0] gain;
  logic [1:0]  src_dly;
  logic [15:0] period;
  logic [19:0] duty;
  logic [1:0]  upd;

  int checks = 0, fails = 0;
  int cyc = 0;
  int acc [2];
  int last_tick = -1;
  bit spacing_ok = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_integral_comp uut (
    .clk_i(clk), .rst_ni(rst_n), .meas_adc_i(meas_adc), .meas_dly_i(meas_dly),
    .ref_i(ref_v), .gain_i(gain), .src_dly_i(src_dly), .period_i(period),
    .duty_o(duty), .upd_o(upd)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int prev, input int m, input int r, input int g);
    int v;
    v = prev - (m - r) * g;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic set_ch(input int c, input int adc, input int dly, input int r,
                        input int g, input bit sd);
    meas_adc[c*7 +: 7] = 7'(adc);
    meas_dly[c*7 +: 7] = 7'(dly);
    ref_v[c*7 +: 7]    = 7'(r);
    gain[c*8 +: 8]     = 8'(g);
    src_dly[c]         = sd;
  endtask

  function automatic int pick(input int c);
    return src_dly[c] ? int'(meas_dly[c*7 +: 7]) : int'(meas_adc[c*7 +: 7]);
  endfunction

  // Wait for the next tick sequence with inputs already set; check both updates.
  task automatic run_sample(input string tag0, input string tag1);
    int guard = 0;
    bit moved = 0;
    int e0, e1;
    e0 = model(acc[0], pick(0), int'(ref_v[6:0]), int'(gain[7:0]));
    e1 = model(acc[1], pick(1), int'(ref_v[13:7]), int'(gain[15:8]));
    forever begin
      @(negedge clk);
      if (upd[0]) break;
      if (int'(duty[9:0]) != acc[0] / 4 || int'(duty[19:10]) != acc[1] / 4) moved = 1;
      guard++;
      if (guard > 200) begin
        check("WATCHDOG", 0, 1);
        return;
      end
    end
    check("R9 hold between ticks", int'(moved), 0);
    check("R7 ch0 pulse first", int'(upd), 1);
    if (spacing_ok) check("R6 tick spacing", cyc - last_tick, int'(period) + 1);
    last_tick = cyc;
    spacing_ok = 1;
    acc[0] = e0;
    check(tag0, int'(duty[9:0]), e0 / 4);
    check("R9 ch1 untouched", int'(duty[19:10]), acc[1] / 4);
    @(negedge clk);
    check("R7 ch1 pulse second", int'(upd), 2);
    acc[1] = e1;
    check(tag1, int'(duty[19:10]), e1 / 4);
    check("R9 ch0 untouched", int'(duty[9:0]), e0 / 4);
    @(negedge clk);
    check("R7 single pulse", int'(upd), 0);
  endtask

  initial begin
    meas_adc = '0; meas_dly = '0; ref_v = '0; gain = '0; src_dly = '0;
    period = 16'd5;
    acc[0] = 0; acc[1] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset duty", int'(duty), 0);
    check("R1 reset pulse", int'(upd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 duty after release", int'(duty), 0);

    // R3 low clamp on ch0, plain rise on ch1
    set_ch(0, 100, 5, 20, 3, 0);
    set_ch(1, 20, 90, 100, 10, 0);
    run_sample("R3 clamp at zero", "R2 ch1 integral");
    // R3 high clamp via delay source (R5), adc value is far off
    set_ch(0, 127, 0, 127, 255, 1);
    set_ch(1, 127, 0, 0, 255, 0);
    run_sample("R5/R3 delay source clamp high", "R3 ch1 clamp at zero");
    check("R3 full scale code", int'(duty[9:0]), 1023);
    // R8 gain zero and equal error hold
    set_ch(0, 0, 127, 64, 0, 0);
    set_ch(1, 33, 33, 33, 200, 1);
    run_sample("R8 gain zero holds", "R8 zero error holds");
    // R4 truncation: ch1 to 3 then 4
    set_ch(1, 0, 50, 1, 3, 0);
    run_sample("R8 hold again", "R4 acc 3 reads 0");
    check("R4 acc 3", int'(duty[19:10]), 0);
    set_ch(1, 90, 0, 1, 1, 1);
    run_sample("R8 hold third", "R4 acc 4 reads 1");
    check("R4 acc 4", int'(duty[19:10]), 1);
    // R5: ignored adc code with delay source selected
    set_ch(0, 0, 70, 64, 2, 1);
    set_ch(1, 127, 60, 64, 5, 1);
    run_sample("R5 ch0 ignores adc", "R5 ch1 ignores adc");

    for (int i = 0; i < 60; i++) begin
      for (int c = 0; c < 2; c++)
        set_ch(c, $urandom_range(127), $urandom_range(127), $urandom_range(127),
               $urandom_range(40), 1'($urandom_range(1)));
      run_sample("R2 random ch0", "R2 random ch1");
    end

    period = 16'd9;
    spacing_ok = 0;
    for (int i = 0; i < 30; i++) begin
      for (int c = 0; c < 2; c++)
        set_ch(c, $urandom_range(127), $urandom_range(127), $urandom_range(127),
               $urandom_range(255), 1'($urandom_range(1)));
      run_sample("R2 random ch0 p9", "R2 random ch1 p9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL WATCHDOG act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule